// File: doc/BRIEF.md
# Busy-Cycle Load Monitor

This block estimates, in hardware, how busy a processor core is. A wide counter moves forward by one on every clock cycle in which the core reports itself active. It stands still whenever the core is in a wait-for-interrupt or another state in which its clock is halted. A separate interval timer runs on the free-running clock, so it keeps counting while the core is idle. At the end of each interval it takes a snapshot of the counter.

The difference between two consecutive snapshots is the number of busy cycles in that interval. The block divides this difference by a programmed full-scale count, which is the number of cycles the interval would contain at full utilisation. The result is an integer busy percentage. For example, 7,000,000 busy cycles against a full scale of 10,000,000 reports 70, which means the core was idle 30% of the time.

The interval length and the full-scale count are inputs that the block latches at the start of every interval. A short sequential divider produces the percentage. The new delta and percentage are presented together with a one-cycle valid pulse.

Top module: `busy_load_monitor`

## Requirements
- R1: The busy counter adds one, modulo 2^CNT_W, on each rising clock edge at which `core_active` is 1, and keeps its value on each edge at which `core_active` is 0.
- R2: The first interval begins at the first rising edge after `rst` is released. Each interval spans exactly L rising edges, and the next interval starts on the following edge. L is the value of `ivl_len` sampled on the interval's first edge, and any value below 12 is used as 12. A change to `ivl_len` during an interval takes effect only from the next interval.
- R3: The reported `delta_out` equals the number of edges in the interval at which `core_active` was 1. It is formed as the difference of the snapshots taken at the ends of consecutive intervals, modulo 2^CNT_W, so it stays correct when the counter wraps.
- R4: `load_pct` equals floor(delta × 100 / F), where F is `full_scale` sampled on the interval's first edge. When delta ≥ F, which includes F = 0, `load_pct` is clamped to 100. `load_pct` never exceeds 100.
- R5: The first interval after reset produces no `load_valid` pulse, and `delta_out` and `load_pct` stay 0 throughout it.
- R6: Every later interval produces exactly one `load_valid` pulse, one cycle wide, within 10 cycles after the interval's last edge and before the next interval ends. `delta_out` and `load_pct` take their new values on the same edge that raises `load_valid`, and hold them until the next pulse.
- R7: A synchronous, active-high `rst` clears the busy counter, the stored snapshot, the interval timer, `delta_out`, `load_pct` and `load_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running clock; it also drives the interval timer |
| rst | input | 1 | Synchronous active-high reset |
| core_active | input | 1 | 1 while the core clock runs, 0 when it is halted or idle |
| ivl_len | input | IVL_W | Interval length in cycles, latched at interval start |
| full_scale | input | FS_W | Full-utilisation cycle count for one interval, latched at interval start |
| delta_out | output | CNT_W | Busy cycles counted in the last reported interval |
| load_pct | output | 7 | Busy percentage, 0 to 100 |
| load_valid | output | 1 | One-cycle pulse when a new delta and percentage are presented |

## Verification
The bench builds the monitor with an 8-bit counter, an 8-bit interval length and an 8-bit full-scale count. With these widths the counter wraps every 256 busy cycles, so wrap-safe deltas are exercised many times within a short run. The full-scale input is swept through all 256 values, including 0, while the interval length moves at random times across and below the minimum of 12. This covers every clamp boundary and mid-interval reprogramming of both settings. The expected deltas and percentages come from a simple arithmetic model of the interval rules.

// File: rtl/load_mon_pkg.sv
package load_mon_pkg;
  localparam int PCT_W     = 7;
  localparam int PCT_FULL  = 100;
  localparam int MIN_IVL   = 12;
  localparam int DIV_STEPS = PCT_W;
  localparam int STEP_W    = $clog2(DIV_STEPS);

  typedef enum logic {
    DIV_IDLE = 1'b0,
    DIV_RUN  = 1'b1
  } div_state_e;
endpackage

// File: rtl/lm_cycle_counter.sv
module lm_cycle_counter #(
  parameter int CNT_W = 64
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             core_active,
  output logic [CNT_W-1:0] cnt_q,
  output logic [CNT_W-1:0] cnt_next
);
  // value the counter will hold after this edge; snapshots take it directly
  assign cnt_next = cnt_q + CNT_W'(core_active);

  always_ff @(posedge clk) begin
    if (rst) cnt_q <= '0;
    else     cnt_q <= cnt_next;
  end

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !core_active |=> cnt_q == $past(cnt_q)); // R1
  AST_BUSY_STEP: assert property (@(posedge clk) disable iff (rst)
    core_active |=> cnt_q == $past(cnt_q) + CNT_W'(1)); // R1
endmodule

// File: rtl/lm_interval_timer.sv
module lm_interval_timer
  import load_mon_pkg::*;
#(
  parameter int IVL_W = 32,
  parameter int FS_W  = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [IVL_W-1:0] ivl_len,
  input  logic [FS_W-1:0]  full_scale,
  output logic             ivl_end,
  output logic [FS_W-1:0]  fs_cur
);
  localparam logic [IVL_W-1:0] LEN_FLOOR = IVL_W'(MIN_IVL);

  logic [IVL_W-1:0] tick_q;
  logic [IVL_W-1:0] len_q;
  logic [FS_W-1:0]  fs_q;
  logic [IVL_W-1:0] len_eff;
  logic             ivl_start;

  assign len_eff   = (ivl_len < LEN_FLOOR) ? LEN_FLOOR : ivl_len;
  assign ivl_start = (tick_q == '0);
  // len_q is at least MIN_IVL, so the last tick is never tick 0
  assign ivl_end   = (tick_q == len_q - IVL_W'(1));
  assign fs_cur    = fs_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      tick_q <= '0;
      len_q  <= LEN_FLOOR;
      fs_q   <= '0;
    end else begin
      if (ivl_start) begin
        len_q <= len_eff;
        fs_q  <= full_scale;
      end
      if (ivl_end) tick_q <= '0;
      else         tick_q <= tick_q + IVL_W'(1);
    end
  end

  AST_TICK_BOUND: assert property (@(posedge clk) disable iff (rst)
    tick_q < len_q); // R2
  AST_LEN_FLOOR: assert property (@(posedge clk) disable iff (rst)
    len_q >= LEN_FLOOR); // R2
  AST_LEN_LATCHED: assert property (@(posedge clk) disable iff (rst)
    !ivl_start |=> $stable(len_q) && $stable(fs_q)); // R2
endmodule

// File: rtl/lm_pct_divider.sv
module lm_pct_divider
  import load_mon_pkg::*;
#(
  parameter int NUM_W = 64,
  parameter int DEN_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             go,
  input  logic [NUM_W-1:0] numer,
  input  logic [DEN_W-1:0] denom,
  output logic             done,
  output logic [PCT_W-1:0] pct
);
  localparam int PROD_W = NUM_W + PCT_W;
  localparam int SHD_W  = DEN_W + PCT_W;
  localparam int CMP_W  = (PROD_W > SHD_W) ? PROD_W : SHD_W;
  localparam logic [STEP_W-1:0] TOP_STEP = STEP_W'(DIV_STEPS - 1);

  div_state_e        state_q;
  logic [CMP_W-1:0]  rem_q;
  logic [CMP_W-1:0]  den_q;
  logic [STEP_W-1:0] step_q;
  logic [PCT_W-1:0]  quo_q;
  logic              clamp_q;
  logic              done_q;
  logic [PCT_W-1:0]  pct_q;

  logic [CMP_W-1:0]  trial;
  logic              fits;
  logic [PCT_W-1:0]  quo_next;

  always_comb begin
    trial    = den_q << step_q;
    fits     = (rem_q >= trial);
    quo_next = quo_q;
    if (fits) quo_next[step_q] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= DIV_IDLE;
      rem_q   <= '0;
      den_q   <= '0;
      step_q  <= '0;
      quo_q   <= '0;
      clamp_q <= 1'b0;
      done_q  <= 1'b0;
      pct_q   <= '0;
    end else begin
      done_q <= 1'b0;
      case (state_q)
        DIV_IDLE: begin
          if (go) begin
            rem_q   <= CMP_W'(numer) * CMP_W'(PCT_FULL);
            den_q   <= CMP_W'(denom);
            clamp_q <= (CMP_W'(numer) >= CMP_W'(denom));
            step_q  <= TOP_STEP;
            quo_q   <= '0;
            state_q <= DIV_RUN;
          end
        end
        DIV_RUN: begin
          if (fits) rem_q <= rem_q - trial;
          quo_q <= quo_next;
          if (step_q == '0) begin
            state_q <= DIV_IDLE;
            done_q  <= 1'b1;
            pct_q   <= clamp_q ? PCT_W'(PCT_FULL) : quo_next;
          end else begin
            step_q <= step_q - STEP_W'(1);
          end
        end
        default: state_q <= DIV_IDLE;
      endcase
    end
  end

  assign done = done_q;
  assign pct  = pct_q;

  AST_GO_WHEN_IDLE: assert property (@(posedge clk) disable iff (rst)
    go |-> state_q == DIV_IDLE); // R6
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    done_q |=> !done_q); // R6
  AST_QUOTIENT_CAP: assert property (@(posedge clk) disable iff (rst)
    done_q |-> pct_q <= PCT_W'(PCT_FULL)); // R4
endmodule

// File: rtl/busy_load_monitor.sv
module busy_load_monitor
  import load_mon_pkg::*;
#(
  parameter int CNT_W = 64,
  parameter int IVL_W = 32,
  parameter int FS_W  = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             core_active,
  input  logic [IVL_W-1:0] ivl_len,
  input  logic [FS_W-1:0]  full_scale,
  output logic [CNT_W-1:0] delta_out,
  output logic [PCT_W-1:0] load_pct,
  output logic             load_valid
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_next;
  logic             ivl_end;
  logic [FS_W-1:0]  fs_cur;

  logic [CNT_W-1:0] last_snap_q;
  logic [CNT_W-1:0] delta_pend_q;
  logic [FS_W-1:0]  fs_pend_q;
  logic             go_q;
  logic             first_q;
  logic             report_q;

  logic             div_done;
  logic [PCT_W-1:0] div_pct;

  lm_cycle_counter #(.CNT_W(CNT_W)) u_counter (
    .clk         (clk),
    .rst         (rst),
    .core_active (core_active),
    .cnt_q       (cnt_q),
    .cnt_next    (cnt_next)
  );

  lm_interval_timer #(.IVL_W(IVL_W), .FS_W(FS_W)) u_timer (
    .clk        (clk),
    .rst        (rst),
    .ivl_len    (ivl_len),
    .full_scale (full_scale),
    .ivl_end    (ivl_end),
    .fs_cur     (fs_cur)
  );

  lm_pct_divider #(.NUM_W(CNT_W), .DEN_W(FS_W)) u_divider (
    .clk   (clk),
    .rst   (rst),
    .go    (go_q),
    .numer (delta_pend_q),
    .denom (fs_pend_q),
    .done  (div_done),
    .pct   (div_pct)
  );

  // snapshot path: modular subtraction keeps the delta right across a wrap
  always_ff @(posedge clk) begin
    if (rst) begin
      last_snap_q  <= '0;
      delta_pend_q <= '0;
      fs_pend_q    <= '0;
      go_q         <= 1'b0;
      first_q      <= 1'b1;
      report_q     <= 1'b0;
    end else begin
      go_q <= 1'b0;
      if (ivl_end) begin
        delta_pend_q <= cnt_next - last_snap_q;
        last_snap_q  <= cnt_next;
        fs_pend_q    <= fs_cur;
        go_q         <= 1'b1;
        report_q     <= !first_q;
        first_q      <= 1'b0;
      end
    end
  end

  // registered outputs, refreshed only when a reportable result is done
  always_ff @(posedge clk) begin
    if (rst) begin
      delta_out  <= '0;
      load_pct   <= '0;
      load_valid <= 1'b0;
    end else begin
      load_valid <= 1'b0;
      if (div_done && report_q) begin
        delta_out  <= delta_pend_q;
        load_pct   <= div_pct;
        load_valid <= 1'b1;
      end
    end
  end

  AST_VALID_PULSE: assert property (@(posedge clk) disable iff (rst)
    load_valid |=> !load_valid); // R6
  AST_OUTPUT_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!load_valid && !$past(rst)) |-> $stable(delta_out) && $stable(load_pct)); // R6
  AST_PCT_LIMIT: assert property (@(posedge clk) disable iff (rst)
    load_pct <= PCT_W'(PCT_FULL)); // R4
  AST_FIRST_QUIET: assert property (@(posedge clk) disable iff (rst)
    first_q |-> !load_valid && delta_out == '0); // R5
  AST_END_WHILE_IDLE: assert property (@(posedge clk) disable iff (rst)
    ivl_end |-> !go_q && !div_done); // R6
endmodule

// File: tb/busy_load_monitor_bench.sv
`timescale 1ns/100ps
module busy_load_monitor_bench;
  localparam int CW = 8;
  localparam int IW = 8;
  localparam int FW = 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          core_active = 1'b0;
  logic [IW-1:0] ivl_len = IW'(20);
  logic [FW-1:0] full_scale = FW'(20);
  logic [CW-1:0] delta_out;
  logic [6:0]    load_pct;
  logic          load_valid;

  busy_load_monitor #(.CNT_W(CW), .IVL_W(IW), .FS_W(FW)) u_busy_load_monitor (
    .clk(clk), .rst(rst), .core_active(core_active), .ivl_len(ivl_len),
    .full_scale(full_scale), .delta_out(delta_out), .load_pct(load_pct),
    .load_valid(load_valid)
  );

  always #2.5 clk = ~clk;

  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // arithmetic model of the interval rules (R2, R3, R4, R5)
  int m_pos, m_len, m_fs, m_acc;
  bit m_first;
  int exp_d [64];
  int exp_p [64];
  int wr = 0;
  int rd = 0;

  always @(posedge clk) begin
    if (rst) begin
      m_pos = 0; m_first = 1'b1; m_acc = 0;
    end else begin
      if (m_pos == 0) begin
        m_len = (int'(ivl_len) < 12) ? 12 : int'(ivl_len);
        m_fs  = int'(full_scale);
        m_acc = 0;
      end
      m_acc += int'(core_active);
      m_pos++;
      if (m_pos == m_len) begin
        if (!m_first) begin
          exp_d[wr % 64] = m_acc % 256;
          exp_p[wr % 64] = (m_acc >= m_fs) ? 100 : (m_acc * 100) / m_fs;
          wr++;
        end
        m_first = 1'b0;
        m_pos = 0;
      end
    end
  end

  int hold_d = 0;
  int hold_p = 0;

  always @(negedge clk) begin
    if (!finished) begin
      if (rst) begin
        rd = wr; hold_d = 0; hold_p = 0;
      end else if (load_valid) begin
        check(rd != wr, "R5 unexpected pulse", 1, 0);
        if (rd != wr) begin
          check(int'(delta_out) == exp_d[rd % 64], "R3 delta", int'(delta_out), exp_d[rd % 64]);
          check(int'(load_pct) == exp_p[rd % 64], "R4 pct", int'(load_pct), exp_p[rd % 64]);
          rd++;
        end
        hold_d = int'(delta_out);
        hold_p = int'(load_pct);
      end else begin
        check(int'(delta_out) == hold_d, "R6 delta hold", int'(delta_out), hold_d);
        check(int'(load_pct) == hold_p, "R6 pct hold", int'(load_pct), hold_p);
      end
    end
  end

  logic [15:0] lf = 16'hACE1;

  function automatic bit act_of(input int mode, input int n, input logic [15:0] l);
    case (mode)
      0: return 1'b1;
      1: return 1'b0;
      2: return (n % 10) < 7;
      3: return (n % 2) == 0;
      default: return l[0];
    endcase
  endfunction

  task automatic do_reset(input int len, input int fs);
    @(negedge clk);
    rst = 1'b1;
    ivl_len = IW'(len);
    full_scale = FW'(fs);
    core_active = 1'b0;
    repeat (3) @(negedge clk);
    check(delta_out == '0, "R7 delta reset", int'(delta_out), 0);
    check(load_pct == '0, "R7 pct reset", int'(load_pct), 0);
    check(load_valid == 1'b0, "R7 valid reset", int'(load_valid), 0);
    rst = 1'b0;
  endtask

  task automatic run_phase(input int len, input int fs, input int mode, input int cycles);
    do_reset(len, fs);
    for (int n = 0; n < cycles; n++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      core_active = act_of(mode, n, lf);
      @(negedge clk);
    end
    check(wr - rd <= 1, "R6 pending results", wr - rd, 1);
  endtask

  initial begin
    // R1 R3: fully busy, the 8-bit counter wraps every 256 cycles
    run_phase(20, 20, 0, 640);
    // R4: 35 of 50 busy gives 70
    run_phase(50, 50, 2, 600);
    // R4: full scale above the interval length
    run_phase(40, 100, 3, 500);
    // R4: delta above full scale clamps to 100
    run_phase(30, 20, 0, 300);
    // R1: idle core holds the counter, load 0
    run_phase(25, 40, 1, 300);
    // R4: full scale of zero reports 100
    run_phase(25, 0, 1, 200);
    // R2: a length below the floor runs as 12
    run_phase(5, 12, 0, 300);
    // R2 R4: sweep every full-scale value, lengths changed mid-interval
    do_reset(40, 0);
    for (int n = 0; n < 20000; n++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      core_active = lf[0] | lf[3];
      if (n % 13 == 0) full_scale = full_scale + FW'(1);
      if (n % 97 == 0) ivl_len = IW'(5 + int'(lf[11:4]) % 60);
      @(negedge clk);
    end
    check(wr - rd <= 1, "R6 pending results", wr - rd, 1);
    // R7: a reset in mid-run restarts counting from scratch
    run_phase(16, 16, 0, 200);
    finished = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #750000;
    if (!finished) begin
      finished = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog run did not complete actual=0 expected=1");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule